// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block sits beside an I2C master engine and turns the engine's single-cycle event pulses into sticky status flags. Seven sources are tracked: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. A mask register selects which flags may raise the single interrupt request line. Two live levels, bus busy and receive shift full, are shown in the status word but are never latched.

Software reaches the block over a small 16-bit register bus with combinational read data. On an interrupt, software typically reads the vector register in a loop. Each read returns the code of the most urgent enabled source and clears that flag. The loop ends when the code is zero.

Flags can also be cleared directly by writing ones to the status register.

Top module: `i2c_irq_vector`

## Requirements
- R1: Reset clears every flag and every mask bit. A one-cycle event pulse sets its flag, and the flag reads as 1 in the status register from the next cycle. The flag positions are: bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 5 stop detected, bit 6 addressed-as-slave.
- R2: Writing a 1 to status bit n (n in 0..6) clears flag n. Writing 0 leaves the flag unchanged. An event arriving in the same cycle as the clear leaves the flag set.
- R3: The mask register uses the same bit positions as the flags. It reads back bits 6:0 as written, and bits 15:7 always read as 0.
- R4: The interrupt line is high exactly when some flag and its mask bit are both 1. A masked event still sets its status flag.
- R5: The vector register reads the code n+1 for the lowest-numbered flag n that is both set and unmasked. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed-as-slave. It reads 0 when no enabled flag is set, and bits 15:3 are always 0.
- R6: A read of the vector register clears the flag it reports at the end of that read cycle, so successive reads walk through the enabled pending sources in priority order down to 0. Masked flags are left set. An event for the reported source in the same cycle keeps that flag set.
- R7: Status bit 11 shows the receive-shift-full level and bit 12 shows the bus-busy level as they are at that moment. Writes to these bits have no effect, and status bits 7 to 10 and 13 to 15 always read as 0.
- R8: The register addresses are 0 for status, 1 for mask and 2 for vector. Address 3 reads as 0. Writes to address 2 or address 3 change no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy | input | 1 | Access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-ready event pulse |
| ev_stop | input | 1 | Stop-detected event pulse |
| ev_aas | input | 1 | Addressed-as-slave event pulse |
| lvl_busy | input | 1 | Live bus-busy level |
| lvl_rsfull | input | 1 | Live receive-shift-full level |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects only at the vector address) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Every one of the 128 flag patterns is raised under four masks: all enabled, none enabled, and the two alternating patterns. Each run checks the status word and the interrupt line, then drains the vector register until it reads zero. This tells apart priority order, the separation between masked and enabled sources, and the clear-on-read side effect, because the masked flags must still be set after the drain. Directed cases cover the remaining behaviour: partial write-one-to-clear, an event colliding with a clear by write or by vector read, the live level bits under writes, and the unused addresses.

// File: rtl/i2c_irq_vector.sv
`timescale 1ns/1ps
module i2c_irq_vector #(
  parameter int DW       = 16,
  parameter int AW       = 2,
  parameter int NSRC     = 7,
  parameter int RSF_BIT  = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          ev_acc_rdy,
  input  logic          ev_rx_rdy,
  input  logic          ev_tx_rdy,
  input  logic          ev_stop,
  input  logic          ev_aas,
  input  logic          lvl_busy,
  input  logic          lvl_rsfull,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CW = $clog2(NSRC + 1);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_VEC  = AW'(2);

  logic [NSRC-1:0] flags, mask, ev, enab, lowest, w1c, vclr;
  logic [CW-1:0]   code;
  logic [DW-1:0]   stat_word;
  logic            unused_hi;

  assign ev     = {ev_aas, ev_stop, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack, ev_arb_lost};
  assign enab   = flags & mask;
  assign lowest = enab & (~enab + {{(NSRC-1){1'b0}}, 1'b1});
  assign w1c    = (wr_en && addr == A_STAT) ? wdata[NSRC-1:0] : '0;
  assign vclr   = (rd_en && addr == A_VEC) ? lowest : '0;
  assign irq    = |enab;
  assign unused_hi = ^wdata[DW-1:NSRC];

  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (enab[i]) code = CW'(i + 1);
  end

  always_comb begin
    stat_word = '0;
    stat_word[NSRC-1:0] = flags;
    stat_word[RSF_BIT]  = lvl_rsfull;
    stat_word[BUSY_BIT] = lvl_busy;
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = stat_word;
      A_MASK:  rdata = {{(DW-NSRC){1'b0}}, mask};
      A_VEC:   rdata = {{(DW-CW){1'b0}}, code};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~w1c & ~vclr) | ev;
      if (wr_en && addr == A_MASK) mask <= wdata[NSRC-1:0];
    end
  end
endmodule

module i2c_irq_vector_chk #(
  parameter int DW       = 16,
  parameter int AW       = 2,
  parameter int NSRC     = 7,
  parameter int BUSY_BIT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_arb_lost,
  input logic          ev_nack,
  input logic          ev_acc_rdy,
  input logic          lvl_busy,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] mask
);
  p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> flags[0]);
  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && wdata[1] && !ev_nack) |=> !flags[1]);
  p_mask_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  p_vec_agrees_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(2)) |-> ((rdata == '0) == !irq));
  p_vec_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2) && rdata == DW'(3) && !ev_acc_rdy) |=> !flags[2]);
  p_busy_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(0)) |-> (rdata[BUSY_BIT] == lvl_busy));
endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(.DW(DW), .AW(AW), .NSRC(NSRC), .BUSY_BIT(BUSY_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_arb_lost(ev_arb_lost), .ev_nack(ev_nack),
  .ev_acc_rdy(ev_acc_rdy), .lvl_busy(lvl_busy), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .flags(flags), .mask(mask)
);

// File: tb/i2c_irq_vector_test.sv
`timescale 1ns/1ps
module i2c_irq_vector_test;
  logic clk = 0, rst_n = 0;
  logic [6:0] ev = '0;
  logic lvl_busy = 0, lvl_rsfull = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_irq_vector uut (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]), .ev_rx_rdy(ev[3]),
    .ev_tx_rdy(ev[4]), .ev_stop(ev[5]), .ev_aas(ev[6]),
    .lvl_busy(lvl_busy), .lvl_rsfull(lvl_rsfull),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic pulse(input logic [6:0] bits);
    @(negedge clk); ev = bits;
    @(posedge clk); #1 ev = '0;
  endtask

  function automatic logic [15:0] lowcode(input logic [6:0] v);
    for (int i = 0; i < 7; i++) if (v[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    logic [6:0] masks [4] = '{7'h7F, 7'h00, 7'h55, 7'h2A};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 R3 R5: reset state
    peek(2'd0, d); check("R1 reset status", d, 16'h0000);
    peek(2'd1, d); check("R3 reset mask", d, 16'h0000);
    peek(2'd2, d); check("R5 reset vector", d, 16'h0000);
    check("R4 reset irq", irq, 1'b0);

    // Sweep over all flag patterns and four masks
    foreach (masks[mi]) begin
      logic [6:0] m;
      m = masks[mi];
      do_write(2'd1, {9'h1FF, m});
      peek(2'd1, d); check("R3 mask readback", d, {9'h0, m});
      for (int p = 0; p < 128; p++) begin
        logic [6:0] pend;
        do_write(2'd0, 16'h007F);
        pulse(7'(p));
        peek(2'd0, d); check("R1 status pattern", d, {9'h0, 7'(p)});
        check("R4 irq", irq, |(7'(p) & m));
        pend = 7'(p) & m;
        for (int k = 0; k < 8; k++) begin
          do_read(2'd2, d);
          check("R5 R6 vector code", d, lowcode(pend));
          if (d == 0) break;
          pend[d-1] = 1'b0;
        end
        peek(2'd0, d); check("R6 masked flags remain", d, {9'h0, 7'(p) & ~m});
      end
    end

    // R2: partial write-one-to-clear, zero write, event collision
    do_write(2'd1, 16'h0000);
    pulse(7'h7F);
    do_write(2'd0, 16'h0005);
    peek(2'd0, d); check("R2 partial clear", d, 16'h007A);
    do_write(2'd0, 16'h0000);
    peek(2'd0, d); check("R2 zero write no change", d, 16'h007A);
    @(negedge clk); addr = 2'd0; wdata = 16'h0002; wr_en = 1; ev = 7'h02;
    @(posedge clk); #1 wr_en = 0; ev = '0;
    peek(2'd0, d); check("R2 event beats clear", d[1], 1'b1);
    check("R4 masked irq low", irq, 1'b0);

    // R6: event during vector read keeps the flag
    do_write(2'd0, 16'h007F);
    do_write(2'd1, 16'h0001);
    pulse(7'h01);
    @(negedge clk); addr = 2'd2; rd_en = 1; ev = 7'h01; #1 d = rdata;
    check("R6 vector before collision", d, 16'd1);
    @(posedge clk); #1 rd_en = 0; ev = '0;
    do_read(2'd2, d); check("R6 event beats read clear", d, 16'd1);
    do_read(2'd2, d); check("R6 drained", d, 16'd0);

    // R7: live levels
    lvl_busy = 1; lvl_rsfull = 1;
    peek(2'd0, d); check("R7 levels high", d, 16'h1800);
    do_write(2'd0, 16'hFFFF);
    peek(2'd0, d); check("R7 write ignored", d, 16'h1800);
    lvl_busy = 0;
    peek(2'd0, d); check("R7 busy follows", d, 16'h0800);
    lvl_rsfull = 0;
    peek(2'd0, d); check("R7 rsfull follows", d, 16'h0000);

    // R8: unused address and writes to the vector address
    do_write(2'd1, 16'h007F);
    pulse(7'h24);
    do_write(2'd2, 16'hFFFF);
    do_write(2'd3, 16'hFFFF);
    peek(2'd0, d); check("R8 flags kept", d, 16'h0024);
    peek(2'd1, d); check("R8 mask kept", d, 16'h007F);
    peek(2'd3, d); check("R8 addr3 reads zero", d, 16'h0000);
    peek(2'd2, d); check("R5 vector access ready first", d, 16'd3);

    // R1: reset clears state
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    peek(2'd0, d); check("R1 reset clears flags", d, 16'h0000);
    peek(2'd1, d); check("R1 reset clears mask", d, 16'h0000);

    finished = 1;
    finish_run();
  end
endmodule